// File: doc/BRIEF.md
# Bus Master Cycle Retry Controller

This block sequences single memory cycles for a DMA-style bus master and handles bus exceptions. When the local engine presents an access (address, direction, write data), the block raises its bus request, waits for the grant, and runs a two-state memory cycle (first state T1, then T2). In T2 it waits for a termination acknowledge. A bus-retry input can end the cycle instead. When that happens the block drops its grant-acknowledge and request for one hold state, sets a retry status flag, and then runs the same access again.

Two configuration inputs select the retry policy. In plain mode the access is re-requested straight after the hold state. In latched mode the block parks in a wait state and only re-requests once software has cleared the status flag and the retry line reads low. The retry line is either taken directly at the clock edge in T2, or, when the bus interface runs in asynchronous mode, passed through a two-stage synchronizer first.

States: IDLE (no access), REQ (request raised, awaiting grant), T1 (address phase), T2 (termination phase, repeats as wait states), HOLD (bus released after retry), PARK (latched mode, awaiting flag clear and retry low). Transitions: IDLE→REQ on start; REQ→T1 on grant; T1→T2 always; T2→HOLD on retry; T2→IDLE on acknowledge without retry; HOLD→REQ in plain mode; HOLD→PARK in latched mode; PARK→REQ when the flag is clear and retry is low.

Top module: `bmr_retry_ctrl`

## Requirements
- R1: After reset, bus_req, bus_gack, cyc_done, retry_stat and retry_irq are 0 and cyc_ready is 1.
- R2: A cyc_start pulse in IDLE raises bus_req one clock later. One clock after bus_grant, bus_gack rises and the cycle enters T1, then T2. bus_ack in T2 without retry makes cyc_done 1 in that same clock, and bus_req, bus_gack are 0 with cyc_ready 1 one clock later.
- R3: Retry seen in T2 ends the cycle: one clock later bus_req and bus_gack are both 0 and retry_stat is 1.
- R4: With cfg_latched=0, bus_req rises again one clock after the hold state. The repeated cycle drives the same bus_addr, bus_write and bus_wdata as the retried one and completes on bus_ack.
- R5: When retry and bus_ack arrive in the same T2 clock, the cycle is treated as retried: cyc_done stays 0 and the hold state follows.
- R6: With cfg_latched=1, bus_req stays 0 after the hold state until retry_stat is 0 and the retry line reads low, in either order. It then rises within three clocks.
- R7: With synchronous sampling, bus_retry is acted on only at a T2 clock edge. A pulse confined to T1 has no effect.
- R8: With cfg_async_sample=1 and cfg_bus_async=1, bus_retry passes two synchronizer flops before it is used. A retry first raised in T2 ends the cycle on the third T2 edge. If bus_ack is present at the first T2 edge, the access completes normally.
- R9: With cfg_async_sample=1 but cfg_bus_async=0, sampling falls back to synchronous: retry raised in T2 releases the bus one clock later.
- R10: retry_irq equals retry_stat. A retry_clr pulse clears the flag one clock later. A retry taken in the same clock as retry_clr leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_latched | input | 1 | 1: wait for flag clear before re-requesting |
| cfg_async_sample | input | 1 | 1: synchronize the retry line |
| cfg_bus_async | input | 1 | 1: bus interface in asynchronous mode |
| cyc_start | input | 1 | Start an access (sampled in IDLE) |
| cyc_addr | input | AW | Access address |
| cyc_write | input | 1 | 1: write access |
| cyc_wdata | input | DW | Write data |
| cyc_ready | output | 1 | Block idle and able to take an access |
| cyc_done | output | 1 | Access terminated normally this clock |
| bus_req | output | 1 | Bus request (hold) |
| bus_grant | input | 1 | Bus grant |
| bus_gack | output | 1 | Bus grant acknowledge, high in T1/T2 |
| bus_addr | output | AW | Address of the current access |
| bus_write | output | 1 | Direction of the current access |
| bus_wdata | output | DW | Write data of the current access |
| bus_ack | input | 1 | Termination acknowledge |
| bus_retry | input | 1 | Bus retry request |
| retry_clr | input | 1 | Software clear strobe for the retry flag |
| retry_stat | output | 1 | Retry status flag |
| retry_irq | output | 1 | Interrupt request, high while the flag is set |

## Verification
A state register stuck in T2, or one that ignores retry, keeps bus_gack high past the clock where a release is due, so it shows one clock after the retry is sampled. If the wrong access is latched or re-latched, a different bus_addr or bus_wdata appears in the T1 of the repeated cycle. A broken park condition shows as bus_req rising while the flag is still set or the line is still high, or as bus_req never rising within three clocks. A synchronizer of the wrong depth moves the release by a clock in the asynchronous tests.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_T1   = 3'd2,
        ST_T2   = 3'd3,
        ST_HOLD = 3'd4,
        ST_PARK = 3'd5
    } bmr_state_e;
endpackage

// File: rtl/bmr_retry_sampler.sv
module bmr_retry_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic use_sync_i,
    output logic seen_o
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= raw_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign seen_o = use_sync_i ? chain[STAGES-1] : raw_i;

    // R8: the synchronized path follows the line one edge per stage
    a_r8_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
        use_sync_i && $past(use_sync_i) && ($past(chain[0]) == 1'b1) && (STAGES == 2)
        |-> chain[STAGES-1]);
endmodule

// File: rtl/bmr_retry_flag.sv
module bmr_retry_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    // R10: a taken retry always leaves the flag set, even against a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R10: a lone clear empties the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/bmr_retry_ctrl.sv
module bmr_retry_ctrl
    import bmr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_latched,
    input  logic          cfg_async_sample,
    input  logic          cfg_bus_async,
    input  logic          cyc_start,
    input  logic [AW-1:0] cyc_addr,
    input  logic          cyc_write,
    input  logic [DW-1:0] cyc_wdata,
    output logic          cyc_ready,
    output logic          cyc_done,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          bus_gack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic          bus_retry,
    input  logic          retry_clr,
    output logic          retry_stat,
    output logic          retry_irq
);
    bmr_state_e state, state_nx;
    logic       retry_seen;
    logic       use_sync;
    logic       retry_take;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          write_q;

    // R9: synchronizer only when the bus itself runs asynchronously
    assign use_sync = cfg_async_sample & cfg_bus_async;

    bmr_retry_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (bus_retry),
        .use_sync_i (use_sync),
        .seen_o     (retry_seen)
    );

    assign retry_take = (state == ST_T2) && retry_seen;

    bmr_retry_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (retry_take),
        .clr_i  (retry_clr),
        .flag_o (retry_stat)
    );

    assign retry_irq = retry_stat;

    // access capture: only in IDLE, so a retried cycle repeats it exactly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (state == ST_IDLE && cyc_start) begin
            addr_q  <= cyc_addr;
            wdata_q <= cyc_wdata;
            write_q <= cyc_write;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cyc_start) state_nx = ST_REQ;
            ST_REQ:  if (bus_grant) state_nx = ST_T1;
            ST_T1:   state_nx = ST_T2;
            ST_T2: begin
                if (retry_seen)   state_nx = ST_HOLD;
                else if (bus_ack) state_nx = ST_IDLE;
            end
            ST_HOLD: state_nx = cfg_latched ? ST_PARK : ST_REQ;
            ST_PARK: if (!retry_stat && !retry_seen) state_nx = ST_REQ;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cyc_ready = 1'b0;
        cyc_done  = 1'b0;
        bus_req   = 1'b0;
        bus_gack  = 1'b0;
        unique case (state)
            ST_IDLE: cyc_ready = 1'b1;
            ST_REQ:  bus_req = 1'b1;
            ST_T1: begin
                bus_req  = 1'b1;
                bus_gack = 1'b1;
            end
            ST_T2: begin
                bus_req  = 1'b1;
                bus_gack = 1'b1;
                cyc_done = bus_ack && !retry_seen;
            end
            ST_HOLD: ;
            ST_PARK: ;
            default: ;
        endcase
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign bus_write = write_q;

    // R2: acknowledge only while the bus is requested
    a_r2_gack_under_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gack |-> bus_req);
    // R3: a retry releases the bus on the next clock
    a_r3_retry_releases: assert property (@(posedge clk) disable iff (!rst_n)
        retry_take |=> (!bus_req && !bus_gack));
    // R5: retry together with acknowledge never reports completion
    a_r5_retry_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_take && bus_ack) |=> (state == ST_HOLD && !cyc_ready));
    // R4: the access stays fixed from capture until the block is idle again
    a_r4_access_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)));
    // R6: parked with the flag set keeps the request low
    a_r6_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARK && retry_stat) |=> !bus_req);
endmodule

// File: tb/bmr_retry_ctrl_test.sv
module bmr_retry_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_latched = 1'b0, cfg_async_sample = 1'b0, cfg_bus_async = 1'b0;
    logic cyc_start = 1'b0, cyc_write = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic [DW-1:0] cyc_wdata = '0;
    logic cyc_ready, cyc_done, bus_req, bus_grant, bus_gack, bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic bus_ack = 1'b0, bus_retry = 1'b0, retry_clr = 1'b0;
    logic retry_stat, retry_irq;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign bus_grant = bus_req;

    bmr_retry_ctrl #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_latched(cfg_latched), .cfg_async_sample(cfg_async_sample), .cfg_bus_async(cfg_bus_async),
        .cyc_start(cyc_start), .cyc_addr(cyc_addr), .cyc_write(cyc_write), .cyc_wdata(cyc_wdata),
        .cyc_ready(cyc_ready), .cyc_done(cyc_done),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_gack(bus_gack),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_retry(bus_retry),
        .retry_clr(retry_clr), .retry_stat(retry_stat), .retry_irq(retry_irq)
    );

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drives a start pulse; returns in REQ; two more steps reach T2
    task automatic begin_access(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
        cyc_addr = a; cyc_write = w; cyc_wdata = d; cyc_start = 1'b1;
        step();
        cyc_start = 1'b0;
    endtask

    task automatic finish_in_t2(input string req);
        bus_ack = 1'b1;
        #1;
        chk(req, {31'd0, cyc_done}, 32'd1);
        step();
        bus_ack = 1'b0;
        chk(req, {30'd0, bus_req, cyc_ready}, 32'd1);
    endtask

    task automatic wait_req(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            if (bus_req) begin
                seen = 1'b1;
                break;
            end
        end
        chk(req, {31'd0, seen}, 32'd1);
    endtask

    task automatic clear_flag();
        retry_clr = 1'b1;
        step();
        retry_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", {27'd0, bus_req, bus_gack, cyc_done, retry_stat, retry_irq}, 32'd0);
        chk("R1", {31'd0, cyc_ready}, 32'd1);

        // R2 plain cycle, both directions
        for (int w = 0; w < 2; w++) begin
            begin_access(16'h0200 + 16'(w), w[0], 16'h3C00 + 16'(w));
            chk("R2 req", {30'd0, bus_req, bus_gack}, 32'd2);
            step();
            chk("R2 t1", {30'd0, bus_req, bus_gack}, 32'd3);
            step();
            finish_in_t2("R2 done");
        end

        // R3 R4 R5 R10: sweep direction x ack-together in plain mode
        cfg_latched = 1'b0;
        for (int w = 0; w < 2; w++) begin
            for (int both = 0; both < 2; both++) begin
                logic [AW-1:0] a;
                logic [DW-1:0] d;
                a = 16'h1000 + 16'(w * 2 + both);
                d = 16'hA500 ^ a;
                begin_access(a, w[0], d);
                step(); step();
                bus_retry = 1'b1;
                bus_ack = both[0];
                retry_clr = 1'b1;      // R10: clear in the same clock as a taken retry
                #1;
                chk("R5 no done", {31'd0, cyc_done}, 32'd0);
                step();
                retry_clr = 1'b0;
                chk("R3 release", {30'd0, bus_req, bus_gack}, 32'd0);
                chk("R10 set wins", {30'd0, retry_stat, retry_irq}, 32'd3);
                bus_retry = 1'b0;
                bus_ack = 1'b0;
                step();
                chk("R4 re-request", {31'd0, bus_req}, 32'd1);
                step();
                chk("R4 addr", {16'd0, bus_addr}, {16'd0, a});
                chk("R4 data", {15'd0, bus_write, bus_wdata}, {15'd0, w[0], d});
                step();
                finish_in_t2("R4 done");
            end
        end
        clear_flag();
        chk("R10 clear", {30'd0, retry_stat, retry_irq}, 32'd0);

        // R6 latched mode, clear-first and line-drop-first
        cfg_latched = 1'b1;
        for (int order = 0; order < 2; order++) begin
            begin_access(16'h2000 + 16'(order), 1'b1, 16'h5A5A);
            step(); step();
            bus_retry = 1'b1;
            step();
            chk("R6 hold", {30'd0, retry_stat, bus_req}, 32'd2);
            step();
            chk("R6 parked", {31'd0, bus_req}, 32'd0);
            if (order == 0) begin
                clear_flag();
                step();
                chk("R6 line still high", {31'd0, bus_req}, 32'd0);
                bus_retry = 1'b0;
            end else begin
                bus_retry = 1'b0;
                step(); step();
                chk("R6 flag still set", {31'd0, bus_req}, 32'd0);
                retry_clr = 1'b1;
                step();
                retry_clr = 1'b0;
                chk("R6 flag cleared", {31'd0, retry_stat}, 32'd0);
            end
            wait_req("R6 release");
            step();
            chk("R6 addr", {16'd0, bus_addr}, {16'd0, 16'h2000 + 16'(order)});
            step();
            finish_in_t2("R6 done");
        end
        cfg_latched = 1'b0;

        // R7 pulse in T1 only is ignored in synchronous mode
        begin_access(16'h3000, 1'b0, 16'h0);
        step();
        bus_retry = 1'b1;
        step();
        bus_retry = 1'b0;
        finish_in_t2("R7 ignored");
        chk("R7 no flag", {31'd0, retry_stat}, 32'd0);

        // R8 asynchronous sampling
        cfg_async_sample = 1'b1;
        cfg_bus_async = 1'b1;
        begin_access(16'h4000, 1'b1, 16'h1111);
        step(); step();
        bus_retry = 1'b1;
        step();
        chk("R8 edge1", {31'd0, bus_gack}, 32'd1);
        step();
        chk("R8 edge2", {31'd0, bus_gack}, 32'd1);
        step();
        chk("R8 edge3", {30'd0, bus_gack, retry_stat}, 32'd1);
        bus_retry = 1'b0;
        step(); step(); step();
        finish_in_t2("R8 retried done");
        clear_flag();
        begin_access(16'h4100, 1'b0, 16'h0);
        step(); step();
        bus_retry = 1'b1;
        finish_in_t2("R8 late completes");
        bus_retry = 1'b0;
        chk("R8 no flag", {31'd0, retry_stat}, 32'd0);
        step(); step(); step();

        // R9 asynchronous request without asynchronous bus falls back
        cfg_bus_async = 1'b0;
        begin_access(16'h5000, 1'b0, 16'h0);
        step(); step();
        bus_retry = 1'b1;
        step();
        chk("R9 fallback", {30'd0, bus_gack, retry_stat}, 32'd1);
        bus_retry = 1'b0;
        step(); step(); step();
        finish_in_t2("R9 done");
        clear_flag();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule